// File: doc/BRIEF.md
# Address Translation Front-End

This block sits between a load/store or fetch unit and a separate page-table walker. Each request carries a virtual address, an access kind (read, write or instruction fetch) and an address-space mode. The block also sees a translation-enable flag, three address-space descriptors (primary, secondary and home) and the prefix base. It first drops the byte offset inside the 4 KB page. It then picks the descriptor that governs the access, and decides whether the address bypasses translation or needs a table walk. Before any walk starts, it rejects addresses that exceed the range of the top-level table.

Walks are handed to the external walker over a request/response handshake. When the walker answers, the block merges the returned write-protection with the mode's permission mask and raises a protection fault for a write to a protected page. It also forwards walker faults. Every successful result passes through low-storage prefix relocation, which swaps the first 8 KB of real storage with the 8 KB block at the prefix base, before it is returned as an absolute address. Each accepted request produces exactly one single-cycle outcome: a completion or a fault. A fault comes with an exception code word built from the page address and the address-space bits.

Top module: `atf_frontend`

## Requirements
- R1: With `dat_en` low, an accepted request completes in the cycle after acceptance. The result is the page-aligned address after prefix relocation, with permissions 3'b111, and no walk is started. Permission bits are {read, write, execute}.
- R2: The low 12 bits of the incoming address are cleared before any use. This holds for the bypass result, for `walk_vaddr` and for the fault code base.
- R3: The address-space mode is encoded 2'b00 primary, 2'b10 secondary, 2'b11 home, and 2'b01 is handled as primary. Primary uses `cr_primary`, secondary uses `cr_secondary` and home uses `cr_home`. The selected descriptor is driven on `walk_asce`.
- R4: Descriptor bit 5 marks a real space. When it is set, the request completes in the cycle after acceptance with the page-aligned address relocated. There is no walk, no range check and no protection fault, and the mode permission mask still applies.
- R5: Descriptor bits [3:2] give the top table type: 2'b11 region-first, 2'b10 region-second, 2'b01 region-third, 2'b00 segment. A nonzero address bit at or above bit 53, 42 or 31 respectively raises fault type 1 (specification) in the cycle after acceptance, with no walk. Region-first is never range-checked.
- R6: In secondary mode, an instruction fetch (access code 2'b10) uses the primary descriptor and keeps only execute permission (3'b001). A data access (2'b00 read, 2'b01 write, 2'b11 read) uses the secondary descriptor and loses execute permission (3'b110 at most). All other modes start from 3'b111.
- R7: When the walker returns a result with `walk_rsp_ro` set, a write raises fault type 2 (protection) and any other access completes with the write bit cleared.
- R8: The fault code is the page-aligned address ORed with the space bits of the descriptor actually used: 0 for primary, 2 for secondary, 3 for home. A protection fault also ORs in 4.
- R9: Relocation: an address below 0x2000 has `prefix` added, an address in [prefix, prefix+0x2000) has `prefix` subtracted, and any other address is unchanged. This applies to bypass results and to walker results alike.
- R10: A walker response with `walk_rsp_fault` set raises fault type 3 (walk fault), with the code formed as in R8 without the protection bit.
- R11: `walk_req` rises in the cycle after a walk is accepted and holds with a stable descriptor and address until `walk_rsp_valid`. While `walk_req` is high, `req_ready` is low and new requests are not taken. The outcome appears in the cycle after the response, and `walk_rsp_valid` has no effect while no walk is pending.
- R12: Each accepted request yields exactly one outcome, either `done_valid` or `fault_valid`, never both, lasting a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_vaddr | input | 64 | Virtual address of the request |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| req_mode | input | 2 | Address-space mode: 00 primary, 01 primary, 10 secondary, 11 home |
| dat_en | input | 1 | Translation enabled |
| cr_primary | input | 64 | Primary space descriptor |
| cr_secondary | input | 64 | Secondary space descriptor |
| cr_home | input | 64 | Home space descriptor |
| prefix | input | 64 | Prefix base for low-storage relocation (8 KB aligned) |
| walk_req | output | 1 | Walk request held until response |
| walk_asce | output | 64 | Descriptor for the walker |
| walk_vaddr | output | 64 | Page-aligned address for the walker |
| walk_rsp_valid | input | 1 | Walker response present |
| walk_rsp_raddr | input | 64 | Real address returned by the walker |
| walk_rsp_ro | input | 1 | Walker found the page write-protected |
| walk_rsp_fault | input | 1 | Walker hit an invalid or malformed entry |
| done_valid | output | 1 | Single-cycle completion pulse |
| done_addr | output | 64 | Absolute address of the completion |
| done_perm | output | 3 | Granted permissions {read, write, execute} |
| fault_valid | output | 1 | Single-cycle fault pulse |
| fault_type | output | 2 | 1 specification, 2 protection, 3 walk fault |
| fault_code | output | 64 | Exception code word |

## Verification
The hardest state to reach from the ports is a walk left pending while the environment pushes on the block. A competing request and a stray walker response must both be shown to have no effect, and the pending walk must still finish with its own descriptor and address. The bench plays the walker itself: it holds the response back for several cycles and drives a second request with a different address into the busy block. It then releases the response and checks that the completion carries the first request's result. Separately, it pulses the response line while no walk is open and confirms that neither outcome appears. The split-space behaviour of secondary mode is reached by issuing fetch and data accesses in the same mode with distinct descriptors, and checking which one reaches `walk_asce`.

// File: rtl/atf_pkg.sv
// Shared encodings for the address translation front-end.
// Assumes the descriptor layout: bit 5 real space, bits [3:2] top table type.
package atf_pkg;

    localparam logic [1:0] MODE_PRI  = 2'b00;
    localparam logic [1:0] MODE_SEC  = 2'b10;
    localparam logic [1:0] MODE_HOME = 2'b11;

    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    localparam logic [1:0] TOP_SEG = 2'b00;
    localparam logic [1:0] TOP_R3  = 2'b01;
    localparam logic [1:0] TOP_R2  = 2'b10;
    localparam logic [1:0] TOP_R1  = 2'b11;

    localparam int DESC_REAL_BIT = 5;
    localparam int DESC_TYPE_LSB = 2;

    localparam logic [2:0] PERM_R   = 3'b100;
    localparam logic [2:0] PERM_W   = 3'b010;
    localparam logic [2:0] PERM_X   = 3'b001;
    localparam logic [2:0] PERM_ALL = 3'b111;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SPEC = 2'd1,
        FLT_PROT = 2'd2,
        FLT_WALK = 2'd3
    } flt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } st_e;

    // Decisions made from one request before any walk
    typedef struct packed {
        logic       bypass;
        logic       range_err;
        logic       is_write;
        logic [1:0] space_bits;
        logic [2:0] perm_mask;
    } dec_t;

endpackage

// File: rtl/atf_decode.sv
// Request decoder: aligns the address, picks the governing address space and
// descriptor, derives the permission mask and checks the top-table range.
// Assumes the caller only samples the outputs when a request is accepted.
module atf_decode
    import atf_pkg::*;
#(
    parameter int AW          = 64,
    parameter int PAGE_BITS   = 12,
    parameter int R2_VA_BITS  = 53,
    parameter int R3_VA_BITS  = 42,
    parameter int SEG_VA_BITS = 31
) (
    input  logic [AW-1:0] vaddr,
    input  logic [1:0]    acc,
    input  logic [1:0]    mode,
    input  logic          dat_en,
    input  logic [AW-1:0] cr_pri,
    input  logic [AW-1:0] cr_sec,
    input  logic [AW-1:0] cr_home,
    output logic [AW-1:0] va_page,
    output logic [AW-1:0] desc,
    output dec_t          dec
);

    localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_BITS;
    localparam int N_CHECKED = 3;

    // Address bit limit for each checked top table type, indexed by type code
    function automatic int limit_of(input int t);
        case (t)
            0:       return SEG_VA_BITS;
            1:       return R3_VA_BITS;
            default: return R2_VA_BITS;
        endcase
    endfunction

    logic       is_fetch;
    logic       is_write;
    logic       in_sec;
    logic [1:0] eff_space;
    logic [1:0] top_type;
    logic       real_space;
    logic [3:0] over;

    // Drop the byte offset inside the page
    assign va_page = vaddr & PAGE_MASK;

    assign is_fetch = (acc == ACC_FETCH);
    assign is_write = (acc == ACC_WRITE);
    assign in_sec   = (mode == MODE_SEC);

    // Pick the address space that governs this access
    always_comb begin
        if (mode == MODE_HOME)
            eff_space = MODE_HOME;
        else if (in_sec && !is_fetch)
            eff_space = MODE_SEC;
        else
            eff_space = MODE_PRI;
    end

    // Route the descriptor of the chosen space
    always_comb begin
        case (eff_space)
            MODE_SEC:  desc = cr_sec;
            MODE_HOME: desc = cr_home;
            default:   desc = cr_pri;
        endcase
    end

    assign real_space = desc[DESC_REAL_BIT];
    assign top_type   = desc[DESC_TYPE_LSB +: 2];

    // One out-of-range detector per checked top table type
    for (genvar g = 0; g < N_CHECKED; g++) begin : g_range
        assign over[g] = |(va_page >> limit_of(g));
    end
    assign over[3] = 1'b0;

    // Assemble the decision record
    always_comb begin
        dec.bypass     = !dat_en || real_space;
        dec.range_err  = dat_en && !real_space && (top_type != TOP_R1) && over[top_type];
        dec.is_write   = is_write;
        dec.space_bits = eff_space;
        if (!dat_en)
            dec.perm_mask = PERM_ALL;
        else if (in_sec && is_fetch)
            dec.perm_mask = PERM_X;
        else if (in_sec)
            dec.perm_mask = PERM_R | PERM_W;
        else
            dec.perm_mask = PERM_ALL;
    end

endmodule

// File: rtl/atf_prefix.sv
// Low-storage prefix relocation: swaps the first window of real storage with
// the window at the prefix base. Assumes the prefix is window aligned.
module atf_prefix #(
    parameter int AW       = 64,
    parameter int WIN_BITS = 13
) (
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] aaddr
);

    logic [AW-1:0] diff;
    logic          in_low;
    logic          in_pfx;

    // Classify the address against both windows
    assign diff   = raddr - prefix;
    assign in_low = (raddr >> WIN_BITS) == '0;
    assign in_pfx = (raddr >= prefix) && ((diff >> WIN_BITS) == '0);

    // Apply the swap
    always_comb begin
        if (in_low)
            aaddr = raddr + prefix;
        else if (in_pfx)
            aaddr = diff;
        else
            aaddr = raddr;
    end

endmodule

// File: rtl/atf_seq.sv
// Sequencer: accepts requests, resolves bypass and range faults at once,
// runs the walker handshake, applies protection and registers one outcome.
// Assumes reloc_addr already holds the relocated form of the address being
// resolved in the current cycle.
module atf_seq
    import atf_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] va_page,
    input  logic [AW-1:0] desc,
    input  dec_t          dec,
    input  logic [AW-1:0] reloc_addr,
    output logic          walk_req,
    output logic [AW-1:0] walk_asce,
    output logic [AW-1:0] walk_vaddr,
    input  logic          walk_rsp_valid,
    input  logic          walk_rsp_ro,
    input  logic          walk_rsp_fault,
    output logic          done_valid,
    output logic [AW-1:0] done_addr,
    output logic [2:0]    done_perm,
    output logic          fault_valid,
    output logic [1:0]    fault_type,
    output logic [AW-1:0] fault_code
);

    localparam logic [AW-1:0] PROT_BIT = AW'(4);

    st_e        state;
    logic       accept;
    logic       rsp;
    logic       lat_write;
    logic [1:0] lat_bits;
    logic [2:0] lat_mask;
    logic [2:0] rsp_perm;

    assign req_ready = (state == ST_IDLE);
    assign walk_req  = (state == ST_WALK);
    assign accept    = req_valid && req_ready;
    assign rsp       = walk_rsp_valid && walk_req;
    assign rsp_perm  = walk_rsp_ro ? (lat_mask & ~PERM_W) : lat_mask;

    // Move between idle and waiting for the walker
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (accept && !dec.bypass && !dec.range_err)
            state <= ST_WALK;
        else if (rsp)
            state <= ST_IDLE;
    end

    // Capture the walk context at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_asce  <= '0;
            walk_vaddr <= '0;
            lat_write  <= 1'b0;
            lat_bits   <= 2'b00;
            lat_mask   <= 3'b000;
        end else if (accept) begin
            walk_asce  <= desc;
            walk_vaddr <= va_page;
            lat_write  <= dec.is_write;
            lat_bits   <= dec.space_bits;
            lat_mask   <= dec.perm_mask;
        end
    end

    // Raise the single-cycle completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_addr  <= '0;
            done_perm  <= 3'b000;
        end else begin
            done_valid <= 1'b0;
            if (accept && dec.bypass && !dec.range_err) begin
                done_valid <= 1'b1;
                done_addr  <= reloc_addr;
                done_perm  <= dec.perm_mask;
            end else if (rsp && !walk_rsp_fault && !(lat_write && walk_rsp_ro)) begin
                done_valid <= 1'b1;
                done_addr  <= reloc_addr;
                done_perm  <= rsp_perm;
            end
        end
    end

    // Raise the single-cycle fault with its code word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_type  <= FLT_NONE;
            fault_code  <= '0;
        end else begin
            fault_valid <= 1'b0;
            if (accept && dec.range_err) begin
                fault_valid <= 1'b1;
                fault_type  <= FLT_SPEC;
                fault_code  <= va_page | AW'(dec.space_bits);
            end else if (rsp && walk_rsp_fault) begin
                fault_valid <= 1'b1;
                fault_type  <= FLT_WALK;
                fault_code  <= walk_vaddr | AW'(lat_bits);
            end else if (rsp && lat_write && walk_rsp_ro) begin
                fault_valid <= 1'b1;
                fault_type  <= FLT_PROT;
                fault_code  <= walk_vaddr | AW'(lat_bits) | PROT_BIT;
            end
        end
    end

endmodule

// File: rtl/atf_frontend.sv
// Address translation front-end top: decoder, relocation and sequencer.
// Assumes one external walker that answers each walk_req exactly once.
module atf_frontend
    import atf_pkg::*;
#(
    parameter int AW          = 64,
    parameter int PAGE_BITS   = 12,
    parameter int WIN_BITS    = 13,
    parameter int R2_VA_BITS  = 53,
    parameter int R3_VA_BITS  = 42,
    parameter int SEG_VA_BITS = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [1:0]    req_acc,
    input  logic [1:0]    req_mode,
    input  logic          dat_en,
    input  logic [AW-1:0] cr_primary,
    input  logic [AW-1:0] cr_secondary,
    input  logic [AW-1:0] cr_home,
    input  logic [AW-1:0] prefix,
    output logic          walk_req,
    output logic [AW-1:0] walk_asce,
    output logic [AW-1:0] walk_vaddr,
    input  logic          walk_rsp_valid,
    input  logic [AW-1:0] walk_rsp_raddr,
    input  logic          walk_rsp_ro,
    input  logic          walk_rsp_fault,
    output logic          done_valid,
    output logic [AW-1:0] done_addr,
    output logic [2:0]    done_perm,
    output logic          fault_valid,
    output logic [1:0]    fault_type,
    output logic [AW-1:0] fault_code
);

    logic [AW-1:0] va_page;
    logic [AW-1:0] desc;
    dec_t          dec;
    logic [AW-1:0] reloc_in;
    logic [AW-1:0] reloc_out;

    atf_decode #(
        .AW(AW), .PAGE_BITS(PAGE_BITS), .R2_VA_BITS(R2_VA_BITS),
        .R3_VA_BITS(R3_VA_BITS), .SEG_VA_BITS(SEG_VA_BITS)
    ) u_decode (
        .vaddr   (req_vaddr),
        .acc     (req_acc),
        .mode    (req_mode),
        .dat_en  (dat_en),
        .cr_pri  (cr_primary),
        .cr_sec  (cr_secondary),
        .cr_home (cr_home),
        .va_page (va_page),
        .desc    (desc),
        .dec     (dec)
    );

    // Relocate the walker result while walking, else the request address
    assign reloc_in = walk_req ? walk_rsp_raddr : va_page;

    atf_prefix #(.AW(AW), .WIN_BITS(WIN_BITS)) u_prefix (
        .raddr  (reloc_in),
        .prefix (prefix),
        .aaddr  (reloc_out)
    );

    atf_seq #(.AW(AW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .va_page        (va_page),
        .desc           (desc),
        .dec            (dec),
        .reloc_addr     (reloc_out),
        .walk_req       (walk_req),
        .walk_asce      (walk_asce),
        .walk_vaddr     (walk_vaddr),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_ro    (walk_rsp_ro),
        .walk_rsp_fault (walk_rsp_fault),
        .done_valid     (done_valid),
        .done_addr      (done_addr),
        .done_perm      (done_perm),
        .fault_valid    (fault_valid),
        .fault_type     (fault_type),
        .fault_code     (fault_code)
    );

endmodule

// File: rtl/atf_frontend_chk.sv
// Protocol checker for the translation front-end, bound to the top.
module atf_frontend_chk #(
    parameter int AW        = 64,
    parameter int PAGE_BITS = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          dat_en,
    input logic          walk_req,
    input logic [AW-1:0] walk_asce,
    input logic [AW-1:0] walk_vaddr,
    input logic          walk_rsp_valid,
    input logic          done_valid,
    input logic [2:0]    done_perm,
    input logic          fault_valid,
    input logic [1:0]    fault_type,
    input logic [AW-1:0] fault_code
);

    // R12: never both outcomes in one cycle
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    // R11: a pending walk holds its request and context
    a_r11_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_rsp_valid |=> walk_req && $stable(walk_asce) && $stable(walk_vaddr));

    // R11: a response closes the walk with an outcome next cycle
    a_r11_resolve: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_rsp_valid |=> (done_valid || fault_valid) && !walk_req && req_ready);

    // R2: the walker only ever sees page-aligned addresses
    a_r2_walk_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> walk_vaddr[PAGE_BITS-1:0] == '0);

    // R1: translation off completes next cycle with full permissions
    a_r1_dat_off: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !dat_en |=> done_valid && done_perm == 3'b111 && !walk_req);

    // R8: a protection fault code carries bit 2 and nothing else below the page
    a_r8_prot_code: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid && fault_type == 2'd2 |-> fault_code[2] && fault_code[PAGE_BITS-1:3] == '0);

endmodule

bind atf_frontend atf_frontend_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .dat_en         (dat_en),
    .walk_req       (walk_req),
    .walk_asce      (walk_asce),
    .walk_vaddr     (walk_vaddr),
    .walk_rsp_valid (walk_rsp_valid),
    .done_valid     (done_valid),
    .done_perm      (done_perm),
    .fault_valid    (fault_valid),
    .fault_type     (fault_type),
    .fault_code     (fault_code)
);

// File: tb/sim_atf_frontend.sv
// Directed bench for the translation front-end; the bench plays the walker.
module sim_atf_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_acc = 2'b00;
    logic [1:0]  req_mode = 2'b00;
    logic        dat_en = 1'b1;
    logic [63:0] cr_primary = '0;
    logic [63:0] cr_secondary = '0;
    logic [63:0] cr_home = '0;
    logic [63:0] prefix = 64'h4_0000;
    logic        walk_req;
    logic [63:0] walk_asce;
    logic [63:0] walk_vaddr;
    logic        walk_rsp_valid = 1'b0;
    logic [63:0] walk_rsp_raddr = '0;
    logic        walk_rsp_ro = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic        done_valid;
    logic [63:0] done_addr;
    logic [2:0]  done_perm;
    logic        fault_valid;
    logic [1:0]  fault_type;
    logic [63:0] fault_code;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    atf_frontend u0 (.*);

    task automatic chk(input string rid, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rid, what, act, exp);
        end
    endtask

    // Present a request at a falling edge; return one cycle later
    task automatic issue(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode);
        req_vaddr = va; req_acc = acc; req_mode = mode; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Play one walker response
    task automatic respond(input logic [63:0] ra, input logic ro, input logic flt);
        walk_rsp_raddr = ra; walk_rsp_ro = ro; walk_rsp_fault = flt; walk_rsp_valid = 1'b1;
        @(negedge clk);
        walk_rsp_valid = 1'b0; walk_rsp_ro = 1'b0; walk_rsp_fault = 1'b0;
    endtask

    task automatic expect_done(input string rid, input logic [63:0] addr, input logic [2:0] perm);
        chk(rid, "done_valid", done_valid, 1);
        chk(rid, "fault_valid", fault_valid, 0);
        chk(rid, "walk_req", walk_req, 0);
        chk(rid, "done_addr", done_addr, addr);
        chk(rid, "done_perm", done_perm, perm);
    endtask

    task automatic expect_fault(input string rid, input logic [1:0] ftype, input logic [63:0] code);
        chk(rid, "fault_valid", fault_valid, 1);
        chk(rid, "done_valid", done_valid, 0);
        chk(rid, "walk_req", walk_req, 0);
        chk(rid, "fault_type", fault_type, ftype);
        chk(rid, "fault_code", fault_code, code);
    endtask

    task automatic expect_walk(input string rid, input logic [63:0] asce, input logic [63:0] va);
        chk(rid, "walk_req", walk_req, 1);
        chk(rid, "req_ready", req_ready, 0);
        chk(rid, "done_valid", done_valid, 0);
        chk(rid, "fault_valid", fault_valid, 0);
        chk(rid, "walk_asce", walk_asce, asce);
        chk(rid, "walk_vaddr", walk_vaddr, va);
    endtask

    task automatic t_reset();
        chk("R11", "reset req_ready", req_ready, 1);
        chk("R11", "reset walk_req", walk_req, 0);
        chk("R12", "reset done_valid", done_valid, 0);
        chk("R12", "reset fault_valid", fault_valid, 0);
    endtask

    task automatic t_dat_off();
        dat_en = 1'b0;
        issue(64'h0000_1234_5678_9abc, 2'b10, 2'b10);
        expect_done("R1 R2", 64'h0000_1234_5678_9000, 3'b111);
        @(negedge clk);
        chk("R12", "pulse width", done_valid, 0);
        dat_en = 1'b1;
    endtask

    task automatic t_prefix();
        dat_en = 1'b0;
        issue(64'h1abc, 2'b00, 2'b00);  expect_done("R9 low", 64'h4_1000, 3'b111);
        issue(64'h1fff, 2'b00, 2'b00);  expect_done("R9 low top", 64'h4_1000, 3'b111);
        issue(64'h2000, 2'b00, 2'b00);  expect_done("R9 above low", 64'h2000, 3'b111);
        issue(64'h4_0fff, 2'b00, 2'b00); expect_done("R9 pfx base", 64'h0, 3'b111);
        issue(64'h4_1fff, 2'b00, 2'b00); expect_done("R9 pfx top", 64'h1000, 3'b111);
        issue(64'h4_2000, 2'b00, 2'b00); expect_done("R9 above pfx", 64'h4_2000, 3'b111);
        dat_en = 1'b1;
    endtask

    task automatic t_modes();
        cr_primary = 64'h1_100c; cr_secondary = 64'h1_700c; cr_home = 64'h1_d00c;
        issue(64'hfff0_0000_0000_0123, 2'b00, 2'b00);
        expect_walk("R3 primary R5 region1", 64'h1_100c, 64'hfff0_0000_0000_0000);
        respond(64'h7000_0000, 1'b0, 1'b0);
        expect_done("R3 primary", 64'h7000_0000, 3'b111);
        issue(64'h5555, 2'b00, 2'b01);
        expect_walk("R3 mode01", 64'h1_100c, 64'h5000);
        respond(64'h7000_1000, 1'b0, 1'b0);
        expect_done("R3 mode01", 64'h7000_1000, 3'b111);
        issue(64'h6666, 2'b10, 2'b11);
        expect_walk("R3 home", 64'h1_d00c, 64'h6000);
        respond(64'h7000_2000, 1'b0, 1'b0);
        expect_done("R3 home", 64'h7000_2000, 3'b111);
        issue(64'h7777, 2'b00, 2'b10);
        expect_walk("R3 R6 sec data", 64'h1_700c, 64'h7000);
        respond(64'h7000_3000, 1'b0, 1'b0);
        expect_done("R6 sec data", 64'h7000_3000, 3'b110);
        issue(64'h8888, 2'b10, 2'b10);
        expect_walk("R6 sec fetch", 64'h1_100c, 64'h8000);
        respond(64'h7000_4000, 1'b0, 1'b0);
        expect_done("R6 sec fetch", 64'h7000_4000, 3'b001);
        issue(64'h9999, 2'b01, 2'b10);
        expect_walk("R6 sec write", 64'h1_700c, 64'h9000);
        respond(64'h7000_5000, 1'b0, 1'b0);
        expect_done("R6 sec write", 64'h7000_5000, 3'b110);
        issue(64'habcd, 2'b00, 2'b00);
        respond(64'h1000, 1'b0, 1'b0);
        expect_done("R9 walk result", 64'h4_1000, 3'b111);
    endtask

    task automatic t_range();
        cr_primary = 64'h1_1000; cr_secondary = 64'h1_7008; cr_home = 64'h1_3004;
        issue(64'h8000_0123, 2'b00, 2'b00);
        expect_fault("R5 segment R8", 2'd1, 64'h8000_0000);
        issue(64'h7fff_f123, 2'b00, 2'b00);
        expect_walk("R5 segment in range", 64'h1_1000, 64'h7fff_f000);
        respond(64'h50_0000, 1'b0, 1'b0);
        expect_done("R5 segment in range", 64'h50_0000, 3'b111);
        issue(64'h0000_0400_0000_0456, 2'b00, 2'b11);
        expect_fault("R5 region3 R8 home", 2'd1, 64'h0000_0400_0000_0003);
        issue(64'h0000_03ff_ffff_f456, 2'b00, 2'b11);
        expect_walk("R5 region3 in range", 64'h1_3004, 64'h0000_03ff_ffff_f000);
        respond(64'h60_0000, 1'b0, 1'b0);
        expect_done("R5 region3 in range", 64'h60_0000, 3'b111);
        issue(64'h0020_0000_0000_0abc, 2'b00, 2'b10);
        expect_fault("R5 region2 R8 sec", 2'd1, 64'h0020_0000_0000_0002);
    endtask

    task automatic t_real();
        cr_primary = 64'h20; cr_secondary = 64'h20;
        issue(64'hffff_0000_1234_5678, 2'b01, 2'b00);
        expect_done("R4 real write", 64'hffff_0000_1234_5000, 3'b111);
        issue(64'hffff_0000_1234_5678, 2'b10, 2'b10);
        expect_done("R4 real sec fetch", 64'hffff_0000_1234_5000, 3'b001);
        issue(64'h8_8888, 2'b01, 2'b10);
        expect_done("R4 real sec write", 64'h8_8000, 3'b110);
    endtask

    task automatic t_prot();
        cr_primary = 64'h1_100c; cr_secondary = 64'h1_700c; cr_home = 64'h1_d00c;
        issue(64'h3_3333, 2'b01, 2'b10);
        respond(64'h70_0000, 1'b1, 1'b0);
        expect_fault("R7 sec write R8", 2'd2, 64'h3_3006);
        issue(64'h4_4444, 2'b01, 2'b00);
        respond(64'h70_0000, 1'b1, 1'b0);
        expect_fault("R7 pri write R8", 2'd2, 64'h4_4004);
        issue(64'h5_5555, 2'b00, 2'b00);
        respond(64'h70_0000, 1'b1, 1'b0);
        expect_done("R7 read of ro", 64'h70_0000, 3'b101);
    endtask

    task automatic t_walk_fault();
        issue(64'h6_6666, 2'b00, 2'b11);
        respond(64'h0, 1'b0, 1'b1);
        expect_fault("R10 home", 2'd3, 64'h6_6003);
        issue(64'h7_7777, 2'b10, 2'b10);
        respond(64'h0, 1'b0, 1'b1);
        expect_fault("R10 sec fetch", 2'd3, 64'h7_7000);
    endtask

    task automatic t_handshake();
        cr_primary = 64'h1_100c; cr_secondary = 64'h1_700c;
        issue(64'h12_3456, 2'b00, 2'b00);
        for (int i = 0; i < 3; i++) begin
            if (i == 1) begin
                req_vaddr = 64'h99_9999; req_mode = 2'b10; req_valid = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            expect_walk("R11 held", 64'h1_100c, 64'h12_3000);
        end
        respond(64'h80_0000, 1'b0, 1'b0);
        expect_done("R11 first request wins", 64'h80_0000, 3'b111);
        chk("R11", "ready after walk", req_ready, 1);
        @(negedge clk);
        chk("R12", "no second outcome", done_valid | fault_valid, 0);
        walk_rsp_raddr = 64'h90_0000; walk_rsp_valid = 1'b1;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        chk("R11", "stray rsp done", done_valid, 0);
        chk("R11", "stray rsp fault", fault_valid, 0);
        chk("R11", "stray rsp ready", req_ready, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dat_off();
        t_prefix();
        t_modes();
        t_range();
        t_real();
        t_prot();
        t_walk_fault();
        t_handshake();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

endmodule